// File: doc/BRIEF.md
# PHY Link Bring-Up Sequencer

This block brings an Ethernet PHY from power-up to a usable link without software help. It drives the command side of an MDIO master, issuing one register transaction at a time. On a start pulse it first soft-resets the PHY and then waits a programmable recovery time. Next it reads the first identifier register and compares it against a list of supported values. When the PHY is supported it takes one of two paths, chosen by a configuration bit sampled at start:

- **Forced mode.** It imposes the configured speed and duplex.
- **Auto mode.** It advertises all four 10/100 abilities, restarts negotiation and polls the status register under a timeout.

After a successful forced setup or negotiation, the block resolves the link mode. It then updates two MAC settings: the full-duplex control bit and the back-to-back inter-packet gap value.

Three flags report the outcome: done, unsupported PHY, or negotiation timeout. The resolved speed and duplex are presented beside them. A timeout or an unsupported PHY leaves the MAC settings as they were. The MDIO bit-level serialisation lies outside this block, behind a simple request/busy handshake. A new start after done runs the whole sequence again.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, done, err_unsupported and an_timeout are 0, mac_full_duplex is 0, mac_ipg is 0x12, link_speed100 and link_full are 0, and no MDIO request is issued until start.
- R2: At most one MDIO command is outstanding. mdio_req is a one-cycle pulse, and the next request comes only after mdio_busy has been seen high and then low for the previous one.
- R3: The sequence opens with a write of 0x8000 (reset, bit 15) to register 0, followed by a write of 0x0000 to register 0, both at PHY address PHY_ADDR.
- R4: At least RECOVERY_CYCLES clock cycles separate the completion of the clearing write from the next request, which is a read of register 2 (identifier 1).
- R5: If the identifier read is not in ID_LIST, the block sets done and err_unsupported and issues no further command. The MAC settings and link outputs stay unchanged.
- R6: In forced mode the block reads register 0 and writes back the read value with bits 13, 12 and 8 cleared. It then sets bit 13 to the sampled speed (1 = 100 Mb/s) and bit 8 to the sampled duplex (1 = full).
- R7: In auto mode the block writes 0x01E1 to register 4 (bits 8..5 for 100 full, 100 half, 10 full, 10 half; selector 00001). It then writes 0x1200 to register 0 (enable bit 12, restart bit 9), and then reads register 1 repeatedly until bits 5 (complete) and 2 (link) are both 1.
- R8: After a successful poll the block reads register 5 and resolves the mode by priority: bit 8 gives 100 full, else bit 7 gives 100 half, else bit 6 gives 10 full, else 10 half.
- R9: If polling has lasted AN_TIMEOUT_CYCLES without success, the block sets done and an_timeout. It issues no register 5 read and keeps the MAC settings and link outputs unchanged.
- R10: On success, link_speed100 and link_full show the resolved mode. Full duplex sets mac_full_duplex to 1 and mac_ipg to 0x15; half duplex sets them to 0 and 0x12. These are updated in the same cycle done rises.
- R11: start is ignored while a sequence runs. A start after done clears all three flags and reruns the sequence with cfg_force, cfg_speed100 and cfg_full sampled at that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for a bring-up sequence |
| cfg_force | input | 1 | 1 = forced mode, 0 = auto-negotiation |
| cfg_speed100 | input | 1 | Forced speed, 1 = 100 Mb/s |
| cfg_full | input | 1 | Forced duplex, 1 = full |
| mdio_req | output | 1 | One-cycle command request to the MDIO master |
| mdio_wr | output | 1 | 1 = write, 0 = read |
| mdio_phy_addr | output | 5 | PHY address of the command |
| mdio_reg | output | 5 | PHY register number of the command |
| mdio_wdata | output | 16 | Write data |
| mdio_busy | input | 1 | MDIO master busy |
| mdio_rdata | input | 16 | Read data, valid when busy falls |
| done | output | 1 | Sequence finished (sticky until next start) |
| err_unsupported | output | 1 | PHY identifier not supported |
| an_timeout | output | 1 | Auto-negotiation poll timed out |
| link_speed100 | output | 1 | Resolved speed, 1 = 100 Mb/s |
| link_full | output | 1 | Resolved duplex, 1 = full |
| mac_full_duplex | output | 1 | MAC full-duplex control bit |
| mac_ipg | output | 7 | MAC back-to-back inter-packet gap value |

## Verification
The assertions assume that the MDIO master raises mdio_busy for at least one cycle after each request and before dropping it. They also assume that mdio_rdata is held valid from the falling edge of busy onward. The bench's PHY model answers every request on the following cycle, holds busy for a fixed number of cycles, and keeps read data stable until the next command.

The model alternates status values that carry only one of the two required bits, so the poll has to wait for both. It sweeps all sixteen partner ability patterns and every forced speed/duplex pair. It also covers an unsupported identifier, a status that never completes, and a start pulse during recovery.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam int DATA_W = 16;
  localparam int REG_W  = 5;
  localparam int ADDR_W = 5;

  localparam logic [REG_W-1:0] REG_CTRL = 5'd0;
  localparam logic [REG_W-1:0] REG_STAT = 5'd1;
  localparam logic [REG_W-1:0] REG_ID1  = 5'd2;
  localparam logic [REG_W-1:0] REG_ADV  = 5'd4;
  localparam logic [REG_W-1:0] REG_LPA  = 5'd5;

  localparam logic [DATA_W-1:0] CTRL_RESET   = 16'h8000;
  localparam logic [DATA_W-1:0] CTRL_SPD100  = 16'h2000;
  localparam logic [DATA_W-1:0] CTRL_AN_EN   = 16'h1000;
  localparam logic [DATA_W-1:0] CTRL_AN_RST  = 16'h0200;
  localparam logic [DATA_W-1:0] CTRL_FULL    = 16'h0100;
  localparam logic [DATA_W-1:0] CTRL_FORCE_CLR = CTRL_SPD100 | CTRL_AN_EN | CTRL_FULL;
  localparam logic [DATA_W-1:0] CTRL_AN_GO   = CTRL_AN_EN | CTRL_AN_RST;

  localparam int STAT_AN_DONE_BIT = 5;
  localparam int STAT_LINK_BIT    = 2;

  localparam int ABIL_100F_BIT = 8;
  localparam int ABIL_100H_BIT = 7;
  localparam int ABIL_10F_BIT  = 6;
  localparam logic [DATA_W-1:0] ADV_VALUE = 16'h01E1;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_SET, S_RST_CLR, S_RECOV, S_ID_RD,
    S_F_RD, S_F_WR, S_A_ADV, S_A_CTL, S_A_POLL, S_A_LPA,
    S_APPLY, S_DONE
  } seq_state_t;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // counter never wraps upward on its own
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mdio_cmd_port.sv
module mdio_cmd_port #(
  parameter int ADDR_W = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] PHY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              issue_wr,
  input  logic [REG_W-1:0]  issue_reg,
  input  logic [DATA_W-1:0] issue_wdata,
  output logic              mdio_req,
  output logic              mdio_wr,
  output logic [ADDR_W-1:0] mdio_phy_addr,
  output logic [REG_W-1:0]  mdio_reg,
  output logic [DATA_W-1:0] mdio_wdata,
  input  logic              mdio_busy,
  input  logic [DATA_W-1:0] mdio_rdata,
  output logic              cmd_done,
  output logic [DATA_W-1:0] rd_data
);
  logic              req_q, wr_q, pend_q, seen_q, done_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] wdata_q, rdat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      wr_q    <= 1'b0;
      pend_q  <= 1'b0;
      seen_q  <= 1'b0;
      done_q  <= 1'b0;
      reg_q   <= '0;
      wdata_q <= '0;
      rdat_q  <= '0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      if (issue && !pend_q) begin
        req_q   <= 1'b1;
        wr_q    <= issue_wr;
        reg_q   <= issue_reg;
        wdata_q <= issue_wdata;
        pend_q  <= 1'b1;
        seen_q  <= 1'b0;
      end else if (pend_q) begin
        if (mdio_busy) begin
          seen_q <= 1'b1;
        end else if (seen_q) begin
          pend_q <= 1'b0;
          done_q <= 1'b1;
          rdat_q <= mdio_rdata;
        end
      end
    end
  end

  assign mdio_req      = req_q;
  assign mdio_wr       = wr_q;
  assign mdio_reg      = reg_q;
  assign mdio_wdata    = wdata_q;
  assign mdio_phy_addr = PHY_ADDR;
  assign cmd_done      = done_q;
  assign rd_data       = rdat_q;

  // R2
  issue_idle_chk: assert property (@(posedge clk) disable iff (rst)
    issue |-> !pend_q);
  // R2
  one_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |=> (!req_q && pend_q));
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd1,
  parameter int RECOVERY_CYCLES   = 150000,
  parameter int AN_TIMEOUT_CYCLES = 50000000,
  parameter int N_IDS = 2,
  parameter logic [N_IDS*DATA_W-1:0] ID_LIST = {16'h0141, 16'h0013},
  parameter int IPG_W = 7,
  parameter logic [IPG_W-1:0] IPG_FULL_VAL = 7'h15,
  parameter logic [IPG_W-1:0] IPG_HALF_VAL = 7'h12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cfg_force,
  input  logic              cfg_speed100,
  input  logic              cfg_full,
  output logic              mdio_req,
  output logic              mdio_wr,
  output logic [ADDR_W-1:0] mdio_phy_addr,
  output logic [REG_W-1:0]  mdio_reg,
  output logic [DATA_W-1:0] mdio_wdata,
  input  logic              mdio_busy,
  input  logic [DATA_W-1:0] mdio_rdata,
  output logic              done,
  output logic              err_unsupported,
  output logic              an_timeout,
  output logic              link_speed100,
  output logic              link_full,
  output logic              mac_full_duplex,
  output logic [IPG_W-1:0]  mac_ipg
);
  localparam int T_MAX = (RECOVERY_CYCLES > AN_TIMEOUT_CYCLES) ?
                         RECOVERY_CYCLES : AN_TIMEOUT_CYCLES;
  localparam int TW = $clog2(T_MAX + 2);

  seq_state_t        state_q;
  logic              sent_q;
  logic              force_q, spd_q, full_q;
  logic              res_spd_q, res_full_q;
  logic [DATA_W-1:0] force_val_q;
  logic              done_q, err_q, tmo_q, lspd_q, lfull_q, macfd_q;
  logic [IPG_W-1:0]  ipg_q;
  logic [TW-1:0]     rec_cnt_q;

  logic              issue, issue_wr, cmd_state, cmd_done;
  logic [REG_W-1:0]  issue_reg;
  logic [DATA_W-1:0] issue_wdata, rd_data;
  logic              tmr_load, tmr_expired;
  logic [TW-1:0]     tmr_val;
  logic [N_IDS-1:0]  id_hit;
  logic              id_ok, poll_ok;

  // identifier match, one comparator per list entry
  for (genvar i = 0; i < N_IDS; i++) begin : g_id
    assign id_hit[i] = (rd_data == ID_LIST[i*DATA_W +: DATA_W]);
  end
  assign id_ok   = |id_hit;
  assign poll_ok = rd_data[STAT_AN_DONE_BIT] && rd_data[STAT_LINK_BIT];

  // command selection per state
  always_comb begin
    cmd_state   = 1'b1;
    issue_wr    = 1'b0;
    issue_reg   = REG_CTRL;
    issue_wdata = '0;
    case (state_q)
      S_RST_SET: begin issue_wr = 1'b1; issue_wdata = CTRL_RESET; end
      S_RST_CLR: begin issue_wr = 1'b1; issue_wdata = '0; end
      S_ID_RD:   issue_reg = REG_ID1;
      S_F_RD:    issue_reg = REG_CTRL;
      S_F_WR:    begin issue_wr = 1'b1; issue_wdata = force_val_q; end
      S_A_ADV:   begin issue_wr = 1'b1; issue_reg = REG_ADV; issue_wdata = ADV_VALUE; end
      S_A_CTL:   begin issue_wr = 1'b1; issue_wdata = CTRL_AN_GO; end
      S_A_POLL:  issue_reg = REG_STAT;
      S_A_LPA:   issue_reg = REG_LPA;
      default:   cmd_state = 1'b0;
    endcase
    issue = cmd_state && !sent_q;
  end

  // timer loads: recovery after the clearing write, timeout after restart
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (cmd_done && state_q == S_RST_CLR) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(RECOVERY_CYCLES);
    end else if (cmd_done && state_q == S_A_CTL) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(AN_TIMEOUT_CYCLES);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      sent_q      <= 1'b0;
      force_q     <= 1'b0;
      spd_q       <= 1'b0;
      full_q      <= 1'b0;
      res_spd_q   <= 1'b0;
      res_full_q  <= 1'b0;
      force_val_q <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      tmo_q       <= 1'b0;
      lspd_q      <= 1'b0;
      lfull_q     <= 1'b0;
      macfd_q     <= 1'b0;
      ipg_q       <= IPG_HALF_VAL;
    end else begin
      if (issue) sent_q <= 1'b1;
      if (cmd_done) sent_q <= 1'b0;
      case (state_q)
        S_IDLE, S_DONE: begin
          if (start) begin
            state_q <= S_RST_SET;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            tmo_q   <= 1'b0;
            force_q <= cfg_force;
            spd_q   <= cfg_speed100;
            full_q  <= cfg_full;
          end
        end
        S_RST_SET: if (cmd_done) state_q <= S_RST_CLR;
        S_RST_CLR: if (cmd_done) state_q <= S_RECOV;
        S_RECOV:   if (tmr_expired) state_q <= S_ID_RD;
        S_ID_RD: begin
          if (cmd_done) begin
            if (!id_ok) begin
              err_q   <= 1'b1;
              done_q  <= 1'b1;
              state_q <= S_DONE;
            end else if (force_q) begin
              state_q <= S_F_RD;
            end else begin
              state_q <= S_A_ADV;
            end
          end
        end
        S_F_RD: begin
          if (cmd_done) begin
            force_val_q <= (rd_data & ~CTRL_FORCE_CLR)
                         | (spd_q  ? CTRL_SPD100 : '0)
                         | (full_q ? CTRL_FULL   : '0);
            res_spd_q  <= spd_q;
            res_full_q <= full_q;
            state_q    <= S_F_WR;
          end
        end
        S_F_WR:  if (cmd_done) state_q <= S_APPLY;
        S_A_ADV: if (cmd_done) state_q <= S_A_CTL;
        S_A_CTL: if (cmd_done) state_q <= S_A_POLL;
        S_A_POLL: begin
          if (cmd_done) begin
            if (poll_ok) begin
              state_q <= S_A_LPA;
            end else if (tmr_expired) begin
              tmo_q   <= 1'b1;
              done_q  <= 1'b1;
              state_q <= S_DONE;
            end
          end
        end
        S_A_LPA: begin
          if (cmd_done) begin
            if (rd_data[ABIL_100F_BIT]) begin
              res_spd_q <= 1'b1; res_full_q <= 1'b1;
            end else if (rd_data[ABIL_100H_BIT]) begin
              res_spd_q <= 1'b1; res_full_q <= 1'b0;
            end else if (rd_data[ABIL_10F_BIT]) begin
              res_spd_q <= 1'b0; res_full_q <= 1'b1;
            end else begin
              res_spd_q <= 1'b0; res_full_q <= 1'b0;
            end
            state_q <= S_APPLY;
          end
        end
        S_APPLY: begin
          lspd_q  <= res_spd_q;
          lfull_q <= res_full_q;
          macfd_q <= res_full_q;
          ipg_q   <= res_full_q ? IPG_FULL_VAL : IPG_HALF_VAL;
          done_q  <= 1'b1;
          state_q <= S_DONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  seq_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  mdio_cmd_port #(
    .ADDR_W   (ADDR_W),
    .REG_W    (REG_W),
    .DATA_W   (DATA_W),
    .PHY_ADDR (PHY_ADDR)
  ) u_port (
    .clk           (clk),
    .rst           (rst),
    .issue         (issue),
    .issue_wr      (issue_wr),
    .issue_reg     (issue_reg),
    .issue_wdata   (issue_wdata),
    .mdio_req      (mdio_req),
    .mdio_wr       (mdio_wr),
    .mdio_phy_addr (mdio_phy_addr),
    .mdio_reg      (mdio_reg),
    .mdio_wdata    (mdio_wdata),
    .mdio_busy     (mdio_busy),
    .mdio_rdata    (mdio_rdata),
    .cmd_done      (cmd_done),
    .rd_data       (rd_data)
  );

  assign done            = done_q;
  assign err_unsupported = err_q;
  assign an_timeout      = tmo_q;
  assign link_speed100   = lspd_q;
  assign link_full       = lfull_q;
  assign mac_full_duplex = macfd_q;
  assign mac_ipg         = ipg_q;

  // recovery length counter for the checks below
  always_ff @(posedge clk) begin
    if (rst || state_q == S_RST_CLR) begin
      rec_cnt_q <= '0;
    end else if (state_q == S_RECOV && rec_cnt_q != {TW{1'b1}}) begin
      rec_cnt_q <= rec_cnt_q + 1'b1;
    end
  end

  // R4
  recovery_len_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ID_RD) |-> (rec_cnt_q >= TW'(RECOVERY_CYCLES)));
  // R5
  err_done_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (done_q && !tmo_q));
  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q && !start) |=> !mdio_req);
  // R7
  adv_value_chk: assert property (@(posedge clk) disable iff (rst)
    (mdio_req && mdio_wr && mdio_reg == REG_ADV) |-> (mdio_wdata == ADV_VALUE));
  // R9
  timeout_keep_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_q) |-> ($stable(macfd_q) && $stable(ipg_q) && $stable(lspd_q)));
  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> done_q);
endmodule

// File: tb/phy_bringup_seq_tb.sv
module phy_bringup_seq_tb;
  localparam int REC = 20;
  localparam int TMO = 200;
  localparam int LAT = 2;
  localparam int LOGN = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, cfg_force = 1'b0, cfg_speed100 = 1'b0, cfg_full = 1'b0;
  logic mdio_req, mdio_wr;
  logic [4:0] mdio_phy_addr, mdio_reg;
  logic [15:0] mdio_wdata;
  logic mdio_busy = 1'b0;
  logic [15:0] mdio_rdata = 16'h0;
  logic done, err_unsupported, an_timeout, link_speed100, link_full, mac_full_duplex;
  logic [6:0] mac_ipg;

  int nchk = 0, nerr = 0, cyc = 0;
  bit finished = 0;

  // PHY model state and command log
  logic [15:0] m_id = 16'h0013, m_ctrl = 16'hB3C0, m_lpa = 16'h0;
  int m_ok_after = 0, poll_n = 0, log_cnt = 0;
  logic        lg_wr   [LOGN];
  logic [4:0]  lg_reg  [LOGN];
  logic [4:0]  lg_addr [LOGN];
  logic [15:0] lg_data [LOGN];
  int          lg_req  [LOGN];
  int          lg_end  [LOGN];

  phy_bringup_seq #(
    .PHY_ADDR(5'd1), .RECOVERY_CYCLES(REC), .AN_TIMEOUT_CYCLES(TMO)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .cfg_force(cfg_force),
    .cfg_speed100(cfg_speed100), .cfg_full(cfg_full),
    .mdio_req(mdio_req), .mdio_wr(mdio_wr), .mdio_phy_addr(mdio_phy_addr),
    .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_busy(mdio_busy),
    .mdio_rdata(mdio_rdata), .done(done), .err_unsupported(err_unsupported),
    .an_timeout(an_timeout), .link_speed100(link_speed100), .link_full(link_full),
    .mac_full_duplex(mac_full_duplex), .mac_ipg(mac_ipg)
  );

  always #10 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc = cyc + 1;
  end

  // MDIO master plus PHY register model
  initial forever begin
    @(negedge clk);
    if (mdio_req) begin
      automatic int idx = (log_cnt < LOGN) ? log_cnt : LOGN - 1;
      lg_wr[idx] = mdio_wr;  lg_reg[idx] = mdio_reg;
      lg_addr[idx] = mdio_phy_addr; lg_data[idx] = mdio_wdata;
      lg_req[idx] = cyc;
      log_cnt = log_cnt + 1;
      @(negedge clk);
      mdio_busy = 1'b1;
      case (lg_reg[idx])
        5'd0: mdio_rdata = m_ctrl;
        5'd1: begin
          if (poll_n >= m_ok_after) mdio_rdata = 16'h0024;
          else mdio_rdata = poll_n[0] ? 16'h0020 : 16'h0004;
          poll_n = poll_n + 1;
        end
        5'd2: mdio_rdata = m_id;
        5'd5: mdio_rdata = m_lpa;
        default: mdio_rdata = 16'h0;
      endcase
      repeat (LAT) @(negedge clk);
      mdio_busy = 1'b0;
      lg_end[idx] = cyc;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nerr = nerr + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input bit f, input bit s, input bit fu, input bit extra);
    log_cnt = 0; poll_n = 0;
    @(negedge clk);
    cfg_force = f; cfg_speed100 = s; cfg_full = fu; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cfg_force = ~f; cfg_speed100 = ~s; cfg_full = ~fu;
    if (extra) begin
      while (log_cnt < 2) @(negedge clk);
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    begin
      automatic int w = 0;
      while (!done && w < 5000) begin @(negedge clk); w = w + 1; end
      chk("R11 sequence finishes", {31'b0, done}, 32'd1);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_head();
    chk("R3 first write reg", {27'b0, lg_reg[0]}, 32'd0);
    chk("R3 first write data", {16'b0, lg_data[0]}, 32'h8000);
    chk("R3 first is write", {31'b0, lg_wr[0]}, 32'd1);
    chk("R3 phy address", {27'b0, lg_addr[0]}, 32'd1);
    chk("R3 clear write", {lg_wr[1], 10'b0, lg_reg[1], lg_data[1]}, 32'h80000000);
    chk("R4 id read reg", {lg_wr[2], 26'b0, lg_reg[2]}, 32'd2);
    chk("R4 recovery gap", {31'b0, (lg_req[2] - lg_end[1]) >= REC}, 32'd1);
    for (int i = 1; i < log_cnt && i < LOGN; i++)
      chk("R2 request after previous busy fell", {31'b0, lg_req[i] > lg_end[i-1]}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr = nerr + 1;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] expw;
    bit es, ef;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 flags", {30'b0, err_unsupported, an_timeout}, 32'd0);
    chk("R1 mac fd", {31'b0, mac_full_duplex}, 32'd0);
    chk("R1 ipg", {25'b0, mac_ipg}, 32'h12);
    chk("R1 link", {30'b0, link_speed100, link_full}, 32'd0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 no request before start", log_cnt, 32'd0);

    // forced sweep
    for (int k = 0; k < 4; k++) begin
      run(1'b1, k[1], k[0], 1'b0);
      expw = (m_ctrl & ~16'h3100) | (k[1] ? 16'h2000 : 16'h0) | (k[0] ? 16'h0100 : 16'h0);
      chk_head();
      chk("R6 command count", log_cnt, 32'd5);
      chk("R6 control read", {lg_wr[3], 26'b0, lg_reg[3]}, 32'd0);
      chk("R6 forced write", {lg_wr[4], 10'b0, lg_reg[4], lg_data[4]}, {1'b1, 10'b0, 5'd0, expw});
      chk("R10 link mode", {30'b0, link_speed100, link_full}, {30'b0, k[1], k[0]});
      chk("R10 mac fd", {31'b0, mac_full_duplex}, {31'b0, k[0]});
      chk("R10 ipg", {25'b0, mac_ipg}, k[0] ? 32'h15 : 32'h12);
      chk("R10 no flags", {30'b0, err_unsupported, an_timeout}, 32'd0);
    end

    // auto sweep over all partner ability patterns
    for (int p = 0; p < 16; p++) begin
      m_lpa = 16'(p) << 5;
      m_ok_after = p % 3;
      run(1'b0, 1'b0, 1'b0, 1'b0);
      chk_head();
      chk("R7 adv write", {lg_wr[3], 10'b0, lg_reg[3], lg_data[3]}, {1'b1, 10'b0, 5'd4, 16'h01E1});
      chk("R7 restart write", {lg_wr[4], 10'b0, lg_reg[4], lg_data[4]}, {1'b1, 10'b0, 5'd0, 16'h1200});
      chk("R7 poll count", log_cnt - 6, m_ok_after + 1);
      chk("R8 partner read", {lg_wr[log_cnt-1], 26'b0, lg_reg[log_cnt-1]}, 32'd5);
      if (p[3])      begin es = 1; ef = 1; end
      else if (p[2]) begin es = 1; ef = 0; end
      else if (p[1]) begin es = 0; ef = 1; end
      else           begin es = 0; ef = 0; end
      chk("R8 resolved mode", {30'b0, link_speed100, link_full}, {30'b0, es, ef});
      chk("R10 auto mac", {24'b0, mac_full_duplex, mac_ipg}, {24'b0, ef, ef ? 7'h15 : 7'h12});
    end

    // timeout keeps previous MAC settings
    run(1'b1, 1'b1, 1'b1, 1'b0);
    m_ok_after = 100000;
    run(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 timeout flag", {29'b0, done, an_timeout, err_unsupported}, 32'b110);
    chk("R9 mac kept", {24'b0, mac_full_duplex, mac_ipg}, {24'b0, 1'b1, 7'h15});
    chk("R9 link kept", {30'b0, link_speed100, link_full}, 32'd3);
    chk("R9 no partner read", {27'b0, lg_reg[log_cnt-1]}, 32'd1);
    chk("R9 polled more than once", {31'b0, log_cnt > 7}, 32'd1);

    // unsupported identifier
    m_ok_after = 0;
    run(1'b1, 1'b0, 1'b0, 1'b0);
    m_id = 16'h1234;
    run(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R5 error flags", {29'b0, done, err_unsupported, an_timeout}, 32'b110);
    repeat (20) @(negedge clk);
    chk("R5 no command after id", log_cnt, 32'd3);
    chk("R5 mac kept", {24'b0, mac_full_duplex, mac_ipg}, {24'b0, 1'b0, 7'h12});
    m_id = 16'h0141;
    run(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R11 restart clears error", {30'b0, err_unsupported, an_timeout}, 32'd0);
    chk("R11 second id supported", {30'b0, link_speed100, link_full}, 32'd2);

    // start during a running sequence is ignored
    run(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R11 extra start ignored", log_cnt, 32'd5);
    chk("R11 mode after extra start", {30'b0, link_speed100, link_full}, 32'd1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule